// File: doc/BRIEF.md
# AES-128 Block Cipher Engine with Stored Round Keys

This block encrypts or decrypts 128-bit blocks under a 128-bit key. Loading a key starts a setup phase. In that phase the key schedule is worked out one round key per clock and written into two small on-chip memories. One memory holds the forward schedule. The other holds the schedule adjusted for decryption. Each block that follows reads its round keys from storage, so no key schedule logic runs while blocks are processed.

Decryption uses the equivalent inverse cipher. It applies InvSubBytes, then InvShiftRows, then InvMixColumns, then the key addition. This keeps the same step order as encryption. The decryption memory holds the forward round keys in reverse order, and InvMixColumns is applied to every key except the first and the last. The core runs one round per cycle. An initial key addition and ten cipher rounds make eleven processing cycles, and one more cycle registers the output.

A typical user pulses the key load once. It then waits for busy to fall, and after that issues any number of blocks, choosing the direction for each block at its start strobe.

Top module: `aes128_core`

## Requirements
- R1: With mode = 1 (encrypt), the core produces the standard AES-128 ciphertext. Byte 0 of a block or key sits in bits [127:120] and byte 15 in bits [7:0]. For key 000102...0f and plaintext 00112233...ff, the result is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: With mode = 0 (decrypt), the core returns the plaintext of any ciphertext made under the stored key, so decrypting an encrypted block gives back the original block.
- R3: A start strobe is accepted on a clock edge where busy is low and key_load is low. The result appears on dout, with done high, exactly 12 clock edges after the accepting edge.
- R4: done is high for a single cycle per block. dout changes only on the edge that raises done and then holds its value.
- R5: An accepted key_load (busy low) raises busy on the next edge. busy stays high for 11 cycles, one per stored round key, and then falls.
- R6: start is ignored while busy is high (during key expansion or while a block is in flight), and also in a cycle where key_load is high. An ignored start never produces a done pulse.
- R7: key_load is ignored while a block is in flight. The block finishes with the old key, and later blocks keep using it.
- R8: The mode is sampled only on the accepting edge. Changing the mode input while a block is in flight has no effect on that block.
- R9: After reset, busy and done are 0 and dout is all zeros.
- R10: A stored key stays in effect for any number of blocks in either direction, until the next accepted key_load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| key_load | input | 1 | Strobe: start expanding key_in |
| key_in | input | 128 | Cipher key, byte 0 in the top bits |
| mode | input | 1 | 1 = encrypt, 0 = decrypt, sampled with start |
| start | input | 1 | Strobe: accept din as a new block |
| din | input | 128 | Input block, byte 0 in the top bits |
| busy | output | 1 | High during key expansion or block processing |
| done | output | 1 | One-cycle strobe: dout holds a fresh result |
| dout | output | 128 | Result block, held until the next done |

## Verification
The hardest cases to reach from the ports are strobes that arrive while the core is busy. One is a start that falls inside the eleven-cycle key expansion. The other is a key_load or a second start that lands in the middle of a block. Both must leave no trace. The stimulus places these strobes a fixed number of cycles after a key load or block start. It then watches the window that follows for stray done pulses. Finally it runs further blocks to check that the stored key and the result of the first block are still intact. Random keys, blocks and directions, mixed with the standard known-answer vector and round trips of encryption followed by decryption, cover the datapath.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
  localparam int BLK_W   = 128;
  localparam int NR      = 10;
  localparam int NUM_RK  = NR + 1;
  localparam int RK_AW   = $clog2(NUM_RK);
  localparam int LATENCY = NUM_RK + 1;
  localparam logic [RK_AW-1:0] LAST_RK = RK_AW'(NR);

  typedef logic [BLK_W-1:0] blk_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = 8'h00; x = a; y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p = p ^ x;
      x = xt(x);
      y = y >> 1;
    end
    return p;
  endfunction

  // multiplicative inverse as a^254, zero maps to zero
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] p, r;
    p = a; r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    v = ginv(x);
    return v ^ rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 3) ^ rotl(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] y);
    return ginv(rotl(y, 1) ^ rotl(y, 3) ^ rotl(y, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {gmul(8'h0e, a0) ^ gmul(8'h0b, a1) ^ gmul(8'h0d, a2) ^ gmul(8'h09, a3),
            gmul(8'h09, a0) ^ gmul(8'h0e, a1) ^ gmul(8'h0b, a2) ^ gmul(8'h0d, a3),
            gmul(8'h0d, a0) ^ gmul(8'h09, a1) ^ gmul(8'h0e, a2) ^ gmul(8'h0b, a3),
            gmul(8'h0b, a0) ^ gmul(8'h0d, a1) ^ gmul(8'h09, a2) ^ gmul(8'h0e, a3)};
  endfunction

  function automatic blk_t inv_mix_blk(input blk_t b);
    blk_t o;
    for (int c = 0; c < 4; c++)
      o[BLK_W-1-32*c -: 32] = inv_mix_col(b[BLK_W-1-32*c -: 32]);
    return o;
  endfunction
endpackage

// File: rtl/aes_round.sv
module aes_round
  import aes128_pkg::*;
(
  input  blk_t st,
  input  blk_t rk,
  input  logic enc,
  input  logic last,
  output blk_t nxt
);
  blk_t sb, sr, mc;

  for (genvar i = 0; i < 16; i++) begin : g_byte
    localparam int ROW   = i % 4;
    localparam int COL   = i / 4;
    localparam int SRC_E = 4 * ((COL + ROW) % 4) + ROW;
    localparam int SRC_D = 4 * ((COL + 4 - ROW) % 4) + ROW;
    assign sb[BLK_W-1-8*i -: 8] = enc ? sbox(st[BLK_W-1-8*i -: 8])
                                      : inv_sbox(st[BLK_W-1-8*i -: 8]);
    assign sr[BLK_W-1-8*i -: 8] = enc ? sb[BLK_W-1-8*SRC_E -: 8]
                                      : sb[BLK_W-1-8*SRC_D -: 8];
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    assign mc[BLK_W-1-32*c -: 32] = enc ? mix_col(sr[BLK_W-1-32*c -: 32])
                                        : inv_mix_col(sr[BLK_W-1-32*c -: 32]);
  end

  assign nxt = (last ? sr : mc) ^ rk;
endmodule

// File: rtl/aes_key_expand.sv
module aes_key_expand
  import aes128_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  blk_t             key,
  output logic             active,
  output logic [RK_AW-1:0] idx,
  output blk_t             enc_rk,
  output blk_t             dec_rk
);
  blk_t        cur, nxt_key;
  logic [7:0]  rcon;
  logic [31:0] temp, n0, n1, n2, n3;

  always_comb begin
    temp    = sub_word({cur[23:0], cur[31:24]}) ^ {rcon, 24'h0};
    n0      = cur[127:96] ^ temp;
    n1      = cur[95:64] ^ n0;
    n2      = cur[63:32] ^ n1;
    n3      = cur[31:0] ^ n2;
    nxt_key = {n0, n1, n2, n3};
  end

  assign enc_rk = cur;
  assign dec_rk = (idx == '0 || idx == LAST_RK) ? cur : inv_mix_blk(cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      cur    <= '0;
      rcon   <= 8'h01;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
      cur    <= key;
      rcon   <= 8'h01;
    end else if (active) begin
      cur  <= nxt_key;
      rcon <= xt(rcon);
      idx  <= idx + 1'b1;
      if (idx == LAST_RK) active <= 1'b0;
    end
  end
endmodule

// File: rtl/aes_rk_store.sv
module aes_rk_store
  import aes128_pkg::*;
#(
  parameter int DEPTH = NUM_RK,
  parameter int AW    = RK_AW,
  parameter int W     = BLK_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr_e,
  input  logic [W-1:0]  wdata_e,
  input  logic [AW-1:0] waddr_d,
  input  logic [W-1:0]  wdata_d,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata_e,
  output logic [W-1:0]  rdata_d
);
  logic [W-1:0] mem_e [DEPTH];
  logic [W-1:0] mem_d [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_e[waddr_e] <= wdata_e;
    rdata_e <= mem_e[raddr];
  end

  always_ff @(posedge clk) begin
    if (we) mem_d[waddr_d] <= wdata_d;
    rdata_d <= mem_d[raddr];
  end
endmodule

// File: rtl/aes128_core.sv
module aes128_core
  import aes128_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               key_load,
  input  logic [BLK_W-1:0]   key_in,
  input  logic               mode,
  input  logic               start,
  input  logic [BLK_W-1:0]   din,
  output logic               busy,
  output logic               done,
  output logic [BLK_W-1:0]   dout
);
  logic             kx_active;
  logic [RK_AW-1:0] kx_idx;
  blk_t             kx_enc, kx_dec;
  logic             running, fin, mode_q;
  logic [RK_AW-1:0] rnd, rd_addr;
  blk_t             st, rk_e, rk_d, rk_sel, rnd_out;
  logic             acc_load, acc_start;

  assign busy      = kx_active | running | fin;
  assign acc_load  = key_load & ~busy;
  assign acc_start = start & ~busy & ~key_load;

  always_comb begin
    if (acc_start)            rd_addr = '0;
    else if (rnd == LAST_RK)  rd_addr = LAST_RK;
    else                      rd_addr = rnd + 1'b1;
  end

  aes_key_expand u_kx (
    .clk(clk), .rst(rst), .load(acc_load), .key(key_in),
    .active(kx_active), .idx(kx_idx), .enc_rk(kx_enc), .dec_rk(kx_dec)
  );

  aes_rk_store u_store (
    .clk(clk), .we(kx_active),
    .waddr_e(kx_idx), .wdata_e(kx_enc),
    .waddr_d(LAST_RK - kx_idx), .wdata_d(kx_dec),
    .raddr(rd_addr), .rdata_e(rk_e), .rdata_d(rk_d)
  );

  assign rk_sel = mode_q ? rk_e : rk_d;

  aes_round u_round (
    .st(st), .rk(rk_sel), .enc(mode_q), .last(rnd == LAST_RK), .nxt(rnd_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      fin     <= 1'b0;
      mode_q  <= 1'b1;
      rnd     <= '0;
      st      <= '0;
      done    <= 1'b0;
      dout    <= '0;
    end else begin
      done <= 1'b0;
      if (acc_start) begin
        st      <= din;
        mode_q  <= mode;
        rnd     <= '0;
        running <= 1'b1;
      end else if (running) begin
        st  <= (rnd == '0) ? (st ^ rk_sel) : rnd_out;
        rnd <= rnd + 1'b1;
        if (rnd == LAST_RK) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end else if (fin) begin
        fin  <= 1'b0;
        dout <= st;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/aes128_core_chk.sv
module aes128_core_chk
  import aes128_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             key_load,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [BLK_W-1:0] dout
);
  localparam logic [3:0] LAT = 4'(LATENCY);
  logic [3:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) lat_cnt <= '0;
    else if (start && !busy && !key_load) lat_cnt <= LAT;
    else if (lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dout));
  assert_lat_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (lat_cnt == 4'd1) |=> done);
  assert_lat_only_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(lat_cnt == 4'd1));
  assert_load_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (key_load && !busy) |=> busy);
  assert_start_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !key_load) |=> busy);
endmodule

bind aes128_core aes128_core_chk u_chk (
  .clk(clk), .rst(rst), .key_load(key_load), .start(start),
  .busy(busy), .done(done), .dout(dout)
);

// File: tb/aes128_core_tb.sv
`timescale 1ns/1ps
module aes128_core_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic key_load = 1'b0, mode = 1'b1, start = 1'b0;
  logic [127:0] key_in = '0, din = '0;
  logic busy, done;
  logic [127:0] dout;
  int checks = 0, errors = 0;

  logic [7:0]   t_sb [256];
  logic [7:0]   t_isb[256];
  logic [127:0] t_rk [11];

  always #2.5 clk = ~clk;

  aes128_core u_dut (
    .clk(clk), .rst(rst), .key_load(key_load), .key_in(key_in), .mode(mode),
    .start(start), .din(din), .busy(busy), .done(done), .dout(dout)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%032h expected=%032h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0, x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] s, input int i);
    return s[127-8*i -: 8];
  endfunction

  function automatic logic [127:0] t_sub(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = inv ? t_isb[gb(s, i)] : t_sb[gb(s, i)];
    return o;
  endfunction

  function automatic logic [127:0] t_shift(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = inv ? gb(s, 4*((c+4-r)%4)+r) : gb(s, 4*((c+r)%4)+r);
    return o;
  endfunction

  function automatic logic [127:0] t_mix(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    logic [7:0] k[4];
    if (inv) k = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    else     k = '{8'h02, 8'h03, 8'h01, 8'h01};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = bm(k[0], gb(s, 4*c+r)) ^ bm(k[1], gb(s, 4*c+(r+1)%4))
                              ^ bm(k[2], gb(s, 4*c+(r+2)%4)) ^ bm(k[3], gb(s, 4*c+(r+3)%4));
    return o;
  endfunction

  task automatic ref_expand(input logic [127:0] k);
    logic [31:0] w[44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t_sb[t[23:16]], t_sb[t[15:8]], t_sb[t[7:0]], t_sb[t[31:24]]} ^ {rc, 24'h0};
        rc = bm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) t_rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] p);
    logic [127:0] s = p ^ t_rk[0];
    for (int r = 1; r <= 10; r++) begin
      s = t_shift(t_sub(s, 0), 0);
      if (r < 10) s = t_mix(s, 0);
      s ^= t_rk[r];
    end
    return s;
  endfunction

  function automatic logic [127:0] ref_dec(input logic [127:0] c);
    logic [127:0] s = c ^ t_rk[10];
    for (int r = 9; r >= 0; r--) begin
      s = t_sub(t_shift(s, 1), 1) ^ t_rk[r];
      if (r > 0) s = t_mix(s, 1);
    end
    return s;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic load_key(input logic [127:0] k, output int nb);
    wait_idle();
    @(negedge clk); key_load = 1'b1; key_in = k;
    @(negedge clk); key_load = 1'b0;
    nb = 0;
    while (busy && nb < 40) begin nb++; @(negedge clk); end
    ref_expand(k);
  endtask

  task automatic run_block(input bit m, input logic [127:0] d, input bit flip,
                           output logic [127:0] res, output int lat);
    wait_idle();
    @(negedge clk); mode = m; din = d; start = 1'b1;
    @(negedge clk); start = 1'b0; din = rnd128(); lat = 1;
    if (flip) mode = ~m;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    res = dout;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%032h expected=%032h", 128'd0, 128'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] res, ct, k2, held;
    int nb, lat, dcnt;
    void'($urandom(32'd20240611));
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, v;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (x != 0 && bm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      v = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
              ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      t_sb[x] = v;
      t_isb[v] = 8'(x);
    end

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && dout == '0, "R9 reset state", {126'd0, busy, done} | dout, '0);

    // known answer
    load_key(128'h000102030405060708090a0b0c0d0e0f, nb);
    check(nb == 11, "R5 busy length", 128'(nb), 128'd11);
    run_block(1'b1, 128'h00112233445566778899aabbccddeeff, 1'b0, res, lat);
    check(res == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R1 known answer", res,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check(lat == 13, "R3 latency (12 edges after accept)", 128'(lat - 1), 128'd12);
    held = res;
    repeat (5) @(negedge clk);
    check(dout == held && !done, "R4 dout held, done single pulse", dout, held);
    run_block(1'b0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, res, lat);
    check(res == 128'h00112233445566778899aabbccddeeff, "R2 known answer decrypt", res,
          128'h00112233445566778899aabbccddeeff);

    // R8: mode flipped after acceptance
    run_block(1'b1, 128'h3243f6a8885a308d313198a2e0370734, 1'b1, res, lat);
    check(res == ref_enc(128'h3243f6a8885a308d313198a2e0370734), "R8 mode change ignored", res,
          ref_enc(128'h3243f6a8885a308d313198a2e0370734));

    // R6: start during key expansion, and start together with key_load
    k2 = rnd128();
    wait_idle();
    @(negedge clk); key_load = 1'b1; key_in = k2; start = 1'b1; din = rnd128();
    @(negedge clk); key_load = 1'b0;
    @(negedge clk); start = 1'b0;
    dcnt = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (done) dcnt++; end
    check(dcnt == 0, "R6 start while busy ignored", 128'(dcnt), 128'd0);
    ref_expand(k2);

    // R7: key_load and start mid-block ignored
    wait_idle();
    @(negedge clk); mode = 1'b1; din = 128'hfeedfacecafebeef0123456789abcdef; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); key_load = 1'b1; key_in = rnd128(); start = 1'b1; din = rnd128();
    @(negedge clk); key_load = 1'b0; start = 1'b0;
    dcnt = 0; res = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done) begin dcnt++; res = dout; end
    end
    check(dcnt == 1, "R6 single done for mid-block start", 128'(dcnt), 128'd1);
    check(res == ref_enc(128'hfeedfacecafebeef0123456789abcdef), "R7 block keeps old key", res,
          ref_enc(128'hfeedfacecafebeef0123456789abcdef));
    check(!busy, "R7 no expansion started", 128'(busy), 128'd0);
    run_block(1'b0, res, 1'b0, ct, lat);
    check(ct == 128'hfeedfacecafebeef0123456789abcdef, "R7 stored key unchanged", ct,
          128'hfeedfacecafebeef0123456789abcdef);

    // random keys, blocks and directions
    for (int k = 0; k < 6; k++) begin
      load_key(rnd128(), nb);
      check(nb == 11, "R5 busy length random key", 128'(nb), 128'd11);
      for (int b = 0; b < 4; b++) begin
        logic [127:0] pt;
        bit m;
        pt = rnd128();
        m = 1'($urandom);
        run_block(m, pt, 1'b0, res, lat);
        check(res == (m ? ref_enc(pt) : ref_dec(pt)), m ? "R1 random encrypt" : "R2 random decrypt",
              res, m ? ref_enc(pt) : ref_dec(pt));
        check(lat == 13, "R3 latency random", 128'(lat - 1), 128'd12);
        run_block(~m, res, 1'b0, ct, lat);
        check(ct == pt, "R10 round trip under stored key", ct, pt);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule